// File: doc/BRIEF.md
# Fractional-N Pulse-Swallow Divider Controller

This block sets the feedback division of a fractional-N synthesizer loop. From an integer pair (a programmable count B and a swallow count A) and an 11-bit fractional numerator FN it works out, once per reference cycle, the division ratio to use in that cycle. The ratio is P*B + A + c. Here c is the carry of a first-order phase accumulator, and its modulus is 1920 or 1968 as a reference-select input picks. Because the modulus is the reference frequency over 10 kHz, one FN step moves the output by 10 kHz. The dual-modulus prescaler runs at either 8 or 6, as a second select input picks.

The block also holds the two counters that steer a P/(P+1) prescaler. The prescaler's output reaches the block as a one-clock strobe per output pulse. Over each divider cycle, the block asks for the long modulus during the first A+c prescaler pulses and for the short modulus for the rest. After B pulses it reloads and sends one divided pulse to the phase detector. Every reference strobe also checks the settings. A setting that breaks the ranges raises an error flag, and the block keeps running on the last setting it accepted.

Top module: `frac_div_ctrl`

## Requirements
- R1: After reset the accepted setting is B=2, A=0, FN=0, modulus 8, denominator 1920. `ratio` reads 16, and `carry`, `cfg_err`, `mod_hi` and `div_pulse` read 0.
- R2: On a clock edge with `ref_tick` high, `ratio` is loaded with P*B + A + c from the setting in force. P is 8 when `psel_six`=0 and 6 when `psel_six`=1.
- R3: The accumulator denominator D is 1920 when `ref_hi`=0 and 1968 when `ref_hi`=1.
- R4: `ratio`, `carry` and `cfg_err` change only on an edge where `ref_tick` is high. Input changes between strobes do not affect them.
- R5: On each strobe the accumulator adds FN. When the sum is at least D, D is subtracted and `carry` is 1 for that reference cycle; otherwise `carry` is 0. The stored sum always stays below the larger denominator.
- R6: In each divider cycle `mod_hi` is high for exactly the first A+c prescaler pulses and low for the rest. It falls only on a prescaler pulse.
- R7: A divider cycle lasts B prescaler pulses. `div_pulse` is high for one clock, in the cycle after the edge that takes the B-th pulse.
- R8: A strobe that sees B<2, A>=B, A>=P or FN>=D sets `cfg_err` to 1 and leaves the accepted setting unchanged. A strobe that sees a legal setting accepts it and clears `cfg_err`.
- R9: At each reload the divider takes B and A from the accepted setting and c from the most recent strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-clock strobe per reference cycle |
| pre_pulse | input | 1 | One-clock strobe per prescaler output pulse |
| cfg_b | input | 4 | Programmable count B |
| cfg_a | input | 3 | Swallow count A |
| cfg_fn | input | 11 | Fractional numerator FN |
| psel_six | input | 1 | Prescaler modulus select: 0 = 8, 1 = 6 |
| ref_hi | input | 1 | Denominator select: 0 = 1920, 1 = 1968 |
| ratio | output | 8 | Division ratio for the current reference cycle |
| carry | output | 1 | Accumulator carry of the last strobe |
| mod_hi | output | 1 | Asks the prescaler for modulus P+1 |
| div_pulse | output | 1 | Divided output pulse |
| cfg_err | output | 1 | Last strobe saw an illegal setting |

## Verification
`ratio`, `carry` and `cfg_err` are due on the first edge after a strobe. The driver queues an expected item for every strobe it issues, and the monitor pops it at the falling edge that follows, so it never samples at a clock edge. `mod_hi` is read at the falling edge just before each prescaler pulse's edge. `div_pulse` is read at the falling edge after the B-th pulse, and again one clock later to confirm it has dropped. The divider only takes a new setting at its next reload, so each divider check drives one cycle to bring the new setting in and then measures the next full cycle. Between strobes the inputs are changed, to show that the registered results hold.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

  // Prescaler modulus chosen by the select bit.
  function automatic int pmod_of(input bit six, input int p_hi, input int p_lo);
    return six ? p_lo : p_hi;
  endfunction

  // Accumulator modulus chosen by the reference select bit.
  function automatic int den_of(input bit hi, input int d_lo, input int d_hi);
    return hi ? d_hi : d_lo;
  endfunction

  // Range check of one setting.
  function automatic bit cfg_legal(input int b, input int a, input int fn,
                                   input int p, input int d);
    return (b >= 2) && (a < b) && (a < p) && (fn < d);
  endfunction

  // Instantaneous division ratio.
  function automatic int ratio_of(input int p, input int b, input int a, input int c);
    return p * b + a + c;
  endfunction

endpackage

// File: rtl/cfg_guard.sv
module cfg_guard
  import frac_div_pkg::*;
#(
  parameter int B_W    = 4,
  parameter int A_W    = 3,
  parameter int FN_W   = 11,
  parameter int P_HI   = 8,
  parameter int P_LO   = 6,
  parameter int DEN_LO = 1920,
  parameter int DEN_HI = 1968,
  parameter int RST_B  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_tick,
  input  logic [B_W-1:0]  in_b,
  input  logic [A_W-1:0]  in_a,
  input  logic [FN_W-1:0] in_fn,
  input  logic            in_six,
  input  logic            in_refhi,
  output logic [B_W-1:0]  sel_b,
  output logic [A_W-1:0]  sel_a,
  output logic [FN_W-1:0] sel_fn,
  output logic            sel_six,
  output logic            sel_refhi,
  output logic [B_W-1:0]  act_b,
  output logic [A_W-1:0]  act_a,
  output logic            err
);

  logic [B_W-1:0]  hold_b;
  logic [A_W-1:0]  hold_a;
  logic [FN_W-1:0] hold_fn;
  logic            hold_six, hold_refhi;
  logic            in_ok;

  assign in_ok = cfg_legal(int'(in_b), int'(in_a), int'(in_fn),
                           pmod_of(in_six, P_HI, P_LO),
                           den_of(in_refhi, DEN_LO, DEN_HI));

  // Setting in force for this strobe: the new one if legal, else the held one.
  always_comb begin
    if (in_ok) begin
      sel_b = in_b;  sel_a = in_a;  sel_fn = in_fn;
      sel_six = in_six;  sel_refhi = in_refhi;
    end else begin
      sel_b = hold_b;  sel_a = hold_a;  sel_fn = hold_fn;
      sel_six = hold_six;  sel_refhi = hold_refhi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_b     <= B_W'(RST_B);
      hold_a     <= '0;
      hold_fn    <= '0;
      hold_six   <= 1'b0;
      hold_refhi <= 1'b0;
      err        <= 1'b0;
    end else if (ref_tick) begin
      err <= !in_ok;
      if (in_ok) begin
        hold_b     <= in_b;
        hold_a     <= in_a;
        hold_fn    <= in_fn;
        hold_six   <= in_six;
        hold_refhi <= in_refhi;
      end
    end
  end

  assign act_b = hold_b;
  assign act_a = hold_a;

  assert_hold_on_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && !in_ok) |=> ($stable(hold_b) && $stable(hold_a) && $stable(hold_fn)
                              && $stable(hold_six) && $stable(hold_refhi)));

  assert_held_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_legal(int'(hold_b), int'(hold_a), int'(hold_fn),
              pmod_of(hold_six, P_HI, P_LO), den_of(hold_refhi, DEN_LO, DEN_HI)));

endmodule

// File: rtl/frac_accum.sv
module frac_accum
  import frac_div_pkg::*;
#(
  parameter int FN_W   = 11,
  parameter int DEN_LO = 1920,
  parameter int DEN_HI = 1968
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ref_tick,
  input  logic [FN_W-1:0] fn,
  input  logic            refhi,
  output logic            wrap,
  output logic            carry_q
);

  localparam int DEN_MAX = (DEN_HI > DEN_LO) ? DEN_HI : DEN_LO;

  logic [FN_W-1:0] acc_q;
  logic [FN_W:0]   sum, den, acc_n;

  assign den   = (FN_W+1)'(den_of(refhi, DEN_LO, DEN_HI));
  assign sum   = {1'b0, acc_q} + {1'b0, fn};
  assign wrap  = (sum >= den);
  assign acc_n = wrap ? (sum - den) : sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else if (ref_tick) begin
      acc_q   <= acc_n[FN_W-1:0];
      carry_q <= wrap;
    end
  end

  assert_acc_below_den_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(acc_q) < DEN_MAX);

  assert_carry_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> $stable(carry_q));

endmodule

// File: rtl/swallow_ctr.sv
module swallow_ctr #(
  parameter int B_W   = 4,
  parameter int A_W   = 3,
  parameter int RST_B = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pre_pulse,
  input  logic [B_W-1:0] ld_b,
  input  logic [A_W-1:0] ld_a,
  input  logic           ld_c,
  output logic           mod_hi,
  output logic           div_pulse
);

  logic [B_W-1:0] b_left, s_left;
  logic           last_pulse;

  assign last_pulse = pre_pulse && (b_left == B_W'(1));
  assign mod_hi     = (s_left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_left    <= B_W'(RST_B);
      s_left    <= '0;
      div_pulse <= 1'b0;
    end else begin
      div_pulse <= last_pulse;
      if (last_pulse) begin
        b_left <= ld_b;
        s_left <= B_W'(ld_a) + B_W'(ld_c);
      end else if (pre_pulse) begin
        b_left <= b_left - B_W'(1);
        if (s_left != '0) s_left <= s_left - B_W'(1);
      end
    end
  end

  assert_swallow_within_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s_left <= b_left);

  assert_div_after_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> $past(pre_pulse));

  assert_prog_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    b_left != '0);

endmodule

// File: rtl/frac_div_ctrl.sv
module frac_div_ctrl
  import frac_div_pkg::*;
#(
  parameter int B_W    = 4,
  parameter int A_W    = 3,
  parameter int FN_W   = 11,
  parameter int P_HI   = 8,
  parameter int P_LO   = 6,
  parameter int DEN_LO = 1920,
  parameter int DEN_HI = 1968,
  parameter int RST_B  = 2,
  localparam int P_MAX   = (P_HI > P_LO) ? P_HI : P_LO,
  localparam int RATIO_W = $clog2(P_MAX * ((1 << B_W) - 1) + (1 << A_W) + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ref_tick,
  input  logic               pre_pulse,
  input  logic [B_W-1:0]     cfg_b,
  input  logic [A_W-1:0]     cfg_a,
  input  logic [FN_W-1:0]    cfg_fn,
  input  logic               psel_six,
  input  logic               ref_hi,
  output logic [RATIO_W-1:0] ratio,
  output logic               carry,
  output logic               mod_hi,
  output logic               div_pulse,
  output logic               cfg_err
);

  logic [B_W-1:0]  sel_b, act_b;
  logic [A_W-1:0]  sel_a, act_a;
  logic [FN_W-1:0] sel_fn;
  logic            sel_six, sel_refhi, wrap;

  cfg_guard #(.B_W(B_W), .A_W(A_W), .FN_W(FN_W), .P_HI(P_HI), .P_LO(P_LO),
              .DEN_LO(DEN_LO), .DEN_HI(DEN_HI), .RST_B(RST_B)) u_guard (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .in_b(cfg_b), .in_a(cfg_a), .in_fn(cfg_fn), .in_six(psel_six), .in_refhi(ref_hi),
    .sel_b(sel_b), .sel_a(sel_a), .sel_fn(sel_fn), .sel_six(sel_six),
    .sel_refhi(sel_refhi), .act_b(act_b), .act_a(act_a), .err(cfg_err)
  );

  frac_accum #(.FN_W(FN_W), .DEN_LO(DEN_LO), .DEN_HI(DEN_HI)) u_accum (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .fn(sel_fn), .refhi(sel_refhi), .wrap(wrap), .carry_q(carry)
  );

  swallow_ctr #(.B_W(B_W), .A_W(A_W), .RST_B(RST_B)) u_swallow (
    .clk(clk), .rst_n(rst_n), .pre_pulse(pre_pulse),
    .ld_b(act_b), .ld_a(act_a), .ld_c(carry),
    .mod_hi(mod_hi), .div_pulse(div_pulse)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ratio <= RATIO_W'(P_HI * RST_B);
    else if (ref_tick)
      ratio <= RATIO_W'(ratio_of(pmod_of(sel_six, P_HI, P_LO),
                                 int'(sel_b), int'(sel_a), int'(wrap)));
  end

  assert_ratio_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> $stable(ratio));

  assert_err_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> $stable(cfg_err));

  assert_mod_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mod_hi) |-> $past(pre_pulse));

endmodule

// File: tb/frac_div_ctrl_tb.sv
module frac_div_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0, pre_pulse = 1'b0;
  logic [3:0]  cfg_b = 4'd2;
  logic [2:0]  cfg_a = 3'd0;
  logic [10:0] cfg_fn = 11'd0;
  logic        psel_six = 1'b0, ref_hi = 1'b0;
  logic [7:0]  ratio;
  logic        carry, mod_hi, div_pulse, cfg_err;

  int checks = 0, errors = 0;

  typedef struct { int ratio; int carry; int err; string tag; } exp_t;
  exp_t sb_q[$];

  // Reference model of the accepted setting and accumulator.
  int m_b = 2, m_a = 0, m_fn = 0, m_six = 0, m_ref = 0, m_acc = 0, m_c = 0;
  logic tick_d = 1'b0;
  bit   done = 1'b0;

  frac_div_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pre_pulse(pre_pulse),
    .cfg_b(cfg_b), .cfg_a(cfg_a), .cfg_fn(cfg_fn), .psel_six(psel_six), .ref_hi(ref_hi),
    .ratio(ratio), .carry(carry), .mod_hi(mod_hi), .div_pulse(div_pulse), .cfg_err(cfg_err)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Driver: issue one strobe and queue the expected registered results.
  task automatic tick(input int b, input int a, input int fn, input int six,
                      input int rh, input string tag);
    int p, d, pm, dm, s;
    exp_t e;
    @(negedge clk);
    cfg_b = 4'(b); cfg_a = 3'(a); cfg_fn = 11'(fn);
    psel_six = 1'(six); ref_hi = 1'(rh); ref_tick = 1'b1;
    p = six ? 6 : 8;
    d = rh ? 1968 : 1920;
    if (b >= 2 && a < b && a < p && fn < d) begin
      m_b = b; m_a = a; m_fn = fn; m_six = six; m_ref = rh; e.err = 0;
    end else e.err = 1;
    pm = m_six ? 6 : 8;
    dm = m_ref ? 1968 : 1920;
    s = m_acc + m_fn;
    m_c = (s >= dm) ? 1 : 0;
    m_acc = m_c ? s - dm : s;
    e.ratio = pm * m_b + m_a + m_c;
    e.carry = m_c;
    e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    ref_tick = 1'b0;
  endtask

  // Monitor: compare at the falling edge after each strobe edge.
  always @(posedge clk) tick_d <= ref_tick;
  always @(negedge clk) begin
    if (tick_d && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      chk(int'(ratio) == e.ratio, {e.tag, " ratio"}, int'(ratio), e.ratio);
      chk(int'(carry) == e.carry, {e.tag, " carry R5"}, int'(carry), e.carry);
      chk(int'(cfg_err) == e.err, {e.tag, " err R8"}, int'(cfg_err), e.err);
    end
  end

  // Drive prescaler pulses for two divider cycles; check the second one.
  task automatic run_div(input int exp_len, input int exp_hi, input string tag);
    int len, hi, seen;
    len = 0; hi = 0; seen = 0;
    while (seen < 2) begin
      @(negedge clk);
      if (mod_hi) hi++;
      len++;
      pre_pulse = 1'b1;
      @(negedge clk);
      pre_pulse = 1'b0;
      if (div_pulse) begin
        seen++;
        if (seen == 2) begin
          chk(len == exp_len, {tag, " cycle length R7"}, len, exp_len);
          chk(hi == exp_hi, {tag, " long-modulus pulses R6 R9"}, hi, exp_hi);
          @(negedge clk);
          chk(div_pulse == 1'b0, {tag, " single-clock pulse R7"}, int'(div_pulse), 0);
        end
        len = 0; hi = 0;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ratio == 8'd16, "R1 ratio", int'(ratio), 16);
    chk(carry == 1'b0, "R1 carry", int'(carry), 0);
    chk(cfg_err == 1'b0, "R1 err", int'(cfg_err), 0);
    chk(mod_hi == 1'b0, "R1 mod_hi", int'(mod_hi), 0);
    chk(div_pulse == 1'b0, "R1 div_pulse", int'(div_pulse), 0);

    // R2 integer ratio under both moduli
    tick(10, 3, 0, 0, 0, "R2 p8");
    tick(10, 3, 0, 1, 0, "R2 p6");
    tick(15, 7, 0, 0, 0, "R2 max");

    // R4: inputs moved without a strobe leave results alone
    @(negedge clk);
    cfg_b = 4'd3; cfg_a = 3'd1; cfg_fn = 11'd100; psel_six = 1'b1;
    repeat (3) @(negedge clk);
    chk(ratio == 8'd127, "R4 ratio held", int'(ratio), 127);
    chk(cfg_err == 1'b0, "R4 err held", int'(cfg_err), 0);

    // R5 fractional accumulation, denominator 1920
    for (int i = 0; i < 5; i++) tick(5, 1, 960, 0, 0, "R5 half");
    for (int i = 0; i < 4; i++) tick(7, 2, 1919, 0, 0, "R5 near-full");
    // R3 denominator 1968 accepts FN 1920, 1920 denominator rejects it
    for (int i = 0; i < 4; i++) tick(6, 4, 1920, 0, 1, "R3 den1968");
    tick(6, 4, 1920, 0, 0, "R3 R8 fn over den");
    tick(6, 4, 1967, 0, 1, "R3 fn top");

    // R8 illegal settings held off
    tick(1, 0, 0, 0, 0, "R8 b below 2");
    tick(4, 4, 0, 0, 0, "R8 a equals b");
    tick(9, 6, 0, 1, 0, "R8 a over p6");
    tick(9, 5, 0, 1, 0, "R8 p6 top legal");

    // R6 R7 R9 divider, no carry
    tick(6, 2, 0, 0, 0, "R9 load");
    run_div(6, 2, "div b6 a2");
    // illegal setting must not reach the divider
    tick(3, 3, 0, 0, 0, "R8 div hold");
    run_div(6, 2, "R8 div held");
    // carry reaches the swallow count
    for (int i = 0; i < 8 && m_c == 0; i++) tick(9, 4, 1500, 0, 0, "R9 seek carry");
    run_div(9, 4 + m_c, "div with carry");
    tick(15, 7, 0, 0, 0, "R7 max");
    run_div(15, 7, "div b15 a7");
    tick(2, 0, 0, 1, 0, "R7 min");
    run_div(2, 0, "div b2 a0");

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R2 scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule